// File: doc/BRIEF.md
# Serial-Link Configuration Register Bank

This block holds the link parameters of a three-lane serial transmitter behind a plain byte-wide write/read bus, which an SPI slave front end drives. A write lands on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Next to the editable parameter bytes, the block keeps a read-only modulo-256 checksum of those bytes. It has two self-clearing command bits: one ends a parameter edit and the other clears the lock monitor. It also has a status byte with a sticky PLL lock-loss flag, a SYNC override, per-lane polarity inversion and a test-pattern length mode.

Calibration offset and gain bytes for two converter cores are written into shadow registers. The datapath sees them through separate active registers. The active registers copy the shadows only while an apply-enable bit is set, so software can stage new values with the bit at 0 and then release them all at once.

Top module: `lnkcfg_regbank`

## Requirements
- R1: Address 0x0C reads the unsigned sum, modulo 256, of the twelve parameter bytes at 0x00 to 0x0B, and reflects a parameter write on the cycle after it. Writes to 0x0C are ignored.
- R2: Writing a value with bit 0 set to address 0x0D raises `cfg_done` for exactly the one cycle after that write. Address 0x0D always reads 0.
- R3: The lock-loss flag becomes 1 after any clock edge at which `pll_locked_n` is 1. It holds until an edge with a write of bit 0 = 1 to 0x0E, where it clears unless `pll_locked_n` is also 1 at that edge, in which case it stays set. Address 0x0E always reads 0.
- R4: Address 0x0F reads {5'b0, params_unsupported, pll_locked_n (live), lock-loss flag}. Writes to it are ignored.
- R5: 0x10 bit 0 is the sync-override enable and 0x11 bit 0 is the sync request. `sync_n_out` is the inverse of the request when the enable is 1, and equals `sync_pin_n` otherwise.
- R6: Bits 2:0 of 0x13 drive `lane_invert[2:0]`, where bit n inverts lane n.
- R7: The eight calibration shadow bytes sit at 0x14 to 0x1B, ordered core*4 + field. 0x1C bit 0 is apply-enable. On each edge where apply-enable is 1, the active copy on `cal_active` (slot s at bits 8s+7:8s) loads the shadows. Otherwise it holds.
- R8: 0x12 bit 0 drives `lane_sync_off` and bit 1 drives `pattern_max` (1 selects the max length interpretation, 0 selects min). Both reset to 0.
- R9: Addresses 0x1D to 0xFF read 0 and ignore writes. Unused upper bits of the control bytes read 0.
- R10: While `rst_n` is low, every register is 0, so `cfg_done` is 0, `lane_invert` is 0, `cal_active` is 0 and `sync_n_out` follows `sync_pin_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pll_locked_n | input | 1 | 1 while the transmitter PLL is unlocked |
| params_unsupported | input | 1 | 1 when the parameter set is not supported |
| sync_pin_n | input | 1 | External active-low SYNC |
| sync_n_out | output | 1 | Effective active-low SYNC |
| cfg_done | output | 1 | One-cycle edit-complete pulse |
| lane_invert | output | 3 | Per-lane polarity inversion |
| lane_sync_off | output | 1 | Far end lacks lane synchronisation |
| pattern_max | output | 1 | Test pattern length uses max interpretation |
| cal_active | output | 64 | Calibration values seen by the datapath |

## Verification
The hardest case to reach is an edge where the lock-loss flag is set and cleared at the same time. This needs a monitor-clear write and an unlocked PLL input in one cycle. The bench forces it directly, then also hits it from random traffic that asserts `pll_locked_n` with low probability. The second hard case is a shadow write made while apply-enable is already 1. The random stream toggles the apply bit often enough that shadow writes land on both sides of it, and the bench model predicts the one-cycle lag each time.

// File: rtl/lnkcfg_pkg.sv
package lnkcfg_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Offsets of the control block, relative to the end of the parameter bytes
  localparam int unsigned OFS_CSUM    = 0;
  localparam int unsigned OFS_DONE    = 1;
  localparam int unsigned OFS_MONCLR  = 2;
  localparam int unsigned OFS_STATUS  = 3;
  localparam int unsigned OFS_SYNCEN  = 4;
  localparam int unsigned OFS_SYNCREQ = 5;
  localparam int unsigned OFS_MODE    = 6;
  localparam int unsigned OFS_POL     = 7;
  localparam int unsigned OFS_CAL     = 8;
endpackage

// File: rtl/lnkcfg_param_file.sv
module lnkcfg_param_file #(
  parameter int unsigned NUM_PARAM = 12,
  parameter int unsigned DW        = 8,
  localparam int unsigned IW       = (NUM_PARAM > 1) ? $clog2(NUM_PARAM) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_idx,
  input  logic [DW-1:0]           wr_data,
  output logic [NUM_PARAM*DW-1:0] param_flat,
  output logic [DW-1:0]           checksum
);
  logic [DW-1:0] param_q [NUM_PARAM];
  logic [DW-1:0] param_d [NUM_PARAM];
  logic          param_en [NUM_PARAM];

  for (genvar g = 0; g < NUM_PARAM; g++) begin : g_prm
    always_comb begin
      param_en[g] = wr_en && (wr_idx == IW'(g));
      param_d[g]  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        param_q[g] <= '0;
      end else if (param_en[g]) begin
        param_q[g] <= param_d[g];
      end
    end

    assign param_flat[g*DW +: DW] = param_q[g];
  end

  // Modulo-2^DW sum; the carry out simply drops off
  always_comb begin
    checksum = '0;
    for (int i = 0; i < NUM_PARAM; i++) begin
      checksum = checksum + param_q[i];
    end
  end
endmodule

// File: rtl/lnkcfg_lock_monitor.sv
module lnkcfg_lock_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_locked_n,
  input  logic clr,
  output logic sticky
);
  logic sticky_q, sticky_d;

  // A loss seen in the clearing cycle survives the clear
  always_comb begin
    sticky_d = sticky_q;
    if (clr)          sticky_d = 1'b0;
    if (pll_locked_n) sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= sticky_d;
  end

  assign sticky = sticky_q;
endmodule

// File: rtl/lnkcfg_cal_shadow.sv
module lnkcfg_cal_shadow #(
  parameter int unsigned NUM_CORES  = 2,
  parameter int unsigned CAL_FIELDS = 4,
  parameter int unsigned DW         = 8,
  localparam int unsigned SLOTS     = NUM_CORES * CAL_FIELDS,
  localparam int unsigned SW        = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SW-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic                apply,
  output logic [SLOTS*DW-1:0] shadow_flat,
  output logic [SLOTS*DW-1:0] active_flat
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DW-1:0] shadow_q, shadow_d, active_q, active_d;
    logic          shadow_en;

    always_comb begin
      shadow_en = wr_en && (wr_idx == SW'(s));
      shadow_d  = wr_data;
      active_d  = shadow_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
      end else if (shadow_en) begin
        shadow_q <= shadow_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active_q <= '0;
      end else if (apply) begin
        active_q <= active_d;
      end
    end

    assign shadow_flat[s*DW +: DW] = shadow_q;
    assign active_flat[s*DW +: DW] = active_q;
  end
endmodule

// File: rtl/lnkcfg_regbank.sv
module lnkcfg_regbank
  import lnkcfg_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 8,
  parameter int unsigned NUM_PARAM  = 12,
  parameter int unsigned NUM_LANES  = 3,
  parameter int unsigned NUM_CORES  = 2,
  parameter int unsigned CAL_FIELDS = 4,
  localparam int unsigned SLOTS     = NUM_CORES * CAL_FIELDS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic                 pll_locked_n,
  input  logic                 params_unsupported,
  input  logic                 sync_pin_n,
  output logic                 sync_n_out,
  output logic                 cfg_done,
  output logic [NUM_LANES-1:0] lane_invert,
  output logic                 lane_sync_off,
  output logic                 pattern_max,
  output logic [SLOTS*DW-1:0]  cal_active
);
  localparam int unsigned IW = (NUM_PARAM > 1) ? $clog2(NUM_PARAM) : 1;
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  localparam logic [AW-1:0] A_CSUM    = AW'(NUM_PARAM + OFS_CSUM);
  localparam logic [AW-1:0] A_DONE    = AW'(NUM_PARAM + OFS_DONE);
  localparam logic [AW-1:0] A_MONCLR  = AW'(NUM_PARAM + OFS_MONCLR);
  localparam logic [AW-1:0] A_STATUS  = AW'(NUM_PARAM + OFS_STATUS);
  localparam logic [AW-1:0] A_SYNCEN  = AW'(NUM_PARAM + OFS_SYNCEN);
  localparam logic [AW-1:0] A_SYNCREQ = AW'(NUM_PARAM + OFS_SYNCREQ);
  localparam logic [AW-1:0] A_MODE    = AW'(NUM_PARAM + OFS_MODE);
  localparam logic [AW-1:0] A_POL     = AW'(NUM_PARAM + OFS_POL);
  localparam logic [AW-1:0] A_CAL0    = AW'(NUM_PARAM + OFS_CAL);
  localparam logic [AW-1:0] A_APPLY   = AW'(NUM_PARAM + OFS_CAL + SLOTS);

  // ---------------- address decode ----------------
  logic prm_wr, cal_wr, done_wr, clr_wr;
  logic syncen_wr, syncreq_wr, mode_wr, pol_wr, apply_wr;
  logic [AW-1:0] cal_ofs;

  always_comb begin
    cal_ofs    = bus_addr - A_CAL0;
    prm_wr     = bus_wr && (bus_addr < AW'(NUM_PARAM));
    cal_wr     = bus_wr && (bus_addr >= A_CAL0) && (bus_addr < A_APPLY);
    done_wr    = bus_wr && (bus_addr == A_DONE)   && bus_wdata[0];
    clr_wr     = bus_wr && (bus_addr == A_MONCLR) && bus_wdata[0];
    syncen_wr  = bus_wr && (bus_addr == A_SYNCEN);
    syncreq_wr = bus_wr && (bus_addr == A_SYNCREQ);
    mode_wr    = bus_wr && (bus_addr == A_MODE);
    pol_wr     = bus_wr && (bus_addr == A_POL);
    apply_wr   = bus_wr && (bus_addr == A_APPLY);
  end

  // ---------------- sub-blocks ----------------
  logic [NUM_PARAM*DW-1:0] param_flat;
  logic [DW-1:0]           checksum;
  logic                    lock_sticky;
  logic [SLOTS*DW-1:0]     cal_shadow;

  lnkcfg_param_file #(.NUM_PARAM(NUM_PARAM), .DW(DW)) u_params (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (prm_wr),
    .wr_idx     (IW'(bus_addr)),
    .wr_data    (bus_wdata),
    .param_flat (param_flat),
    .checksum   (checksum)
  );

  lnkcfg_lock_monitor u_lockmon (
    .clk          (clk),
    .rst_n        (rst_n),
    .pll_locked_n (pll_locked_n),
    .clr          (clr_wr),
    .sticky       (lock_sticky)
  );

  // ---------------- control registers ----------------
  logic                 sync_en_q, sync_en_d;
  logic                 sync_req_q, sync_req_d;
  logic [1:0]           mode_q, mode_d;
  logic [NUM_LANES-1:0] pol_q, pol_d;
  logic                 apply_q, apply_d;
  logic                 done_q, done_d;

  always_comb begin
    sync_en_d  = bus_wdata[0];
    sync_req_d = bus_wdata[0];
    mode_d     = bus_wdata[1:0];
    pol_d      = bus_wdata[NUM_LANES-1:0];
    apply_d    = bus_wdata[0];
    done_d     = done_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_en_q <= 1'b0;
    else if (syncen_wr) sync_en_q <= sync_en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_req_q <= 1'b0;
    else if (syncreq_wr) sync_req_q <= sync_req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_wr) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= '0;
    else if (pol_wr) pol_q <= pol_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) apply_q <= 1'b0;
    else if (apply_wr) apply_q <= apply_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  lnkcfg_cal_shadow #(.NUM_CORES(NUM_CORES), .CAL_FIELDS(CAL_FIELDS), .DW(DW)) u_cal (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cal_wr),
    .wr_idx      (SW'(cal_ofs)),
    .wr_data     (bus_wdata),
    .apply       (apply_q),
    .shadow_flat (cal_shadow),
    .active_flat (cal_active)
  );

  // ---------------- outputs ----------------
  assign sync_n_out    = sync_en_q ? ~sync_req_q : sync_pin_n;
  assign cfg_done      = done_q;
  assign lane_invert   = pol_q;
  assign lane_sync_off = mode_q[0];
  assign pattern_max   = mode_q[1];

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PARAM; i++) begin
      if (bus_addr == AW'(i)) bus_rdata = param_flat[i*DW +: DW];
    end
    for (int s = 0; s < SLOTS; s++) begin
      if (bus_addr == A_CAL0 + AW'(s)) bus_rdata = cal_shadow[s*DW +: DW];
    end
    if (bus_addr == A_CSUM)    bus_rdata = checksum;
    if (bus_addr == A_STATUS)  bus_rdata = DW'({params_unsupported, pll_locked_n, lock_sticky});
    if (bus_addr == A_SYNCEN)  bus_rdata = DW'(sync_en_q);
    if (bus_addr == A_SYNCREQ) bus_rdata = DW'(sync_req_q);
    if (bus_addr == A_MODE)    bus_rdata = DW'(mode_q);
    if (bus_addr == A_POL)     bus_rdata = DW'(pol_q);
    if (bus_addr == A_APPLY)   bus_rdata = DW'(apply_q);
  end
endmodule

// File: rtl/lnkcfg_checker.sv
module lnkcfg_checker #(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned NUM_PARAM = 12,
  parameter int unsigned SLOTS     = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [AW-1:0]       bus_addr,
  input logic [DW-1:0]       bus_wdata,
  input logic [DW-1:0]       bus_rdata,
  input logic                pll_locked_n,
  input logic                cfg_done,
  input logic                sticky,
  input logic                apply,
  input logic [SLOTS*DW-1:0] cal_active
);
  localparam logic [AW-1:0] C_DONE   = AW'(NUM_PARAM + 1);
  localparam logic [AW-1:0] C_MONCLR = AW'(NUM_PARAM + 2);
  localparam logic [AW-1:0] C_STATUS = AW'(NUM_PARAM + 3);
  localparam logic [AW-1:0] C_APPLY  = AW'(NUM_PARAM + 8 + SLOTS);

  logic clr_req;
  assign clr_req = bus_wr && (bus_addr == C_MONCLR) && bus_wdata[0];

  AST_DONE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> $past(bus_wr && (bus_addr == C_DONE) && bus_wdata[0])); // R2

  AST_LOSS_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pll_locked_n |=> sticky); // R3

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pll_locked_n) && !$past(clr_req)) |-> (sticky == $past(sticky))); // R3

  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == C_STATUS) |-> (bus_rdata[1] == pll_locked_n && bus_rdata[0] == sticky)); // R4

  AST_CAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(apply) |-> $stable(cal_active)); // R7

  AST_COMMAND_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == C_DONE || bus_addr == C_MONCLR) |-> (bus_rdata == '0)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > C_APPLY) |-> (bus_rdata == '0)); // R9
endmodule

bind lnkcfg_regbank lnkcfg_checker #(
  .AW(AW), .DW(DW), .NUM_PARAM(NUM_PARAM), .SLOTS(SLOTS)
) u_lnkcfg_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .pll_locked_n (pll_locked_n),
  .cfg_done     (cfg_done),
  .sticky       (lock_sticky),
  .apply        (apply_q),
  .cal_active   (cal_active)
);

// File: tb/test_lnkcfg_regbank.sv
module test_lnkcfg_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata;
  logic        pll_locked_n, params_unsupported, sync_pin_n;
  logic        sync_n_out, cfg_done, lane_sync_off, pattern_max;
  logic [2:0]  lane_invert;
  logic [63:0] cal_active;

  always #10 clk = ~clk; // 50 MHz

  lnkcfg_regbank i_lnkcfg_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_locked_n(pll_locked_n),
    .params_unsupported(params_unsupported), .sync_pin_n(sync_pin_n),
    .sync_n_out(sync_n_out), .cfg_done(cfg_done), .lane_invert(lane_invert),
    .lane_sync_off(lane_sync_off), .pattern_max(pattern_max), .cal_active(cal_active)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model
  logic [7:0] m_param [12];
  logic [7:0] m_shadow [8];
  logic [7:0] m_active [8];
  logic       m_sync_en, m_sync_req, m_apply, m_sticky, m_done;
  logic [1:0] m_mode;
  logic [2:0] m_pol;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] csum();
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 12; i++) s = s + m_param[i];
    return s;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a < 8'd12)                 return m_param[a];
    if (a == 8'd12)                return csum();
    if (a == 8'd15)                return {5'b0, params_unsupported, pll_locked_n, m_sticky};
    if (a == 8'd16)                return {7'b0, m_sync_en};
    if (a == 8'd17)                return {7'b0, m_sync_req};
    if (a == 8'd18)                return {6'b0, m_mode};
    if (a == 8'd19)                return {5'b0, m_pol};
    if (a >= 8'd20 && a < 8'd28)   return m_shadow[a - 8'd20];
    if (a == 8'd28)                return {7'b0, m_apply};
    return 8'h00; // command bytes and unmapped space
  endfunction

  function automatic string rd_req(input logic [7:0] a);
    if (a < 8'd13)  return "R1";
    if (a < 8'd15)  return "R2/R3";
    if (a == 8'd15) return "R4";
    if (a < 8'd18)  return "R5";
    if (a == 8'd18) return "R8";
    if (a == 8'd19) return "R6";
    if (a < 8'd29)  return "R7";
    return "R9";
  endfunction

  task automatic check_read(input logic [7:0] a);
    bus_addr = a;
    #1;
    check(bus_rdata == exp_rd(a), rd_req(a), bus_rdata, exp_rd(a));
  endtask

  task automatic check_outputs();
    logic exp_sync;
    exp_sync = m_sync_en ? ~m_sync_req : sync_pin_n;
    check(cfg_done == m_done, "R2 cfg_done", cfg_done, m_done);
    check(sync_n_out == exp_sync, "R5 sync_n_out", sync_n_out, exp_sync);
    check(lane_invert == m_pol, "R6 lane_invert", lane_invert, m_pol);
    check({pattern_max, lane_sync_off} == m_mode, "R8 mode outputs", {pattern_max, lane_sync_off}, m_mode);
    for (int s = 0; s < 8; s++)
      check(cal_active[s*8 +: 8] == m_active[s], "R7 cal_active", cal_active[s*8 +: 8], m_active[s]);
  endtask

  // one clock: drive at negedge, model at the edge, check after it
  task automatic step(input bit wr, input logic [7:0] a, input logic [7:0] d,
                      input bit pll, input bit uns, input bit pin, input logic [7:0] ra);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    pll_locked_n = pll; params_unsupported = uns; sync_pin_n = pin;
    @(posedge clk);
    m_done = wr && a == 8'd13 && d[0];
    if (m_apply) for (int s = 0; s < 8; s++) m_active[s] = m_shadow[s];
    m_sticky = pll | (m_sticky & ~(wr && a == 8'd14 && d[0]));
    if (wr) begin
      if (a < 8'd12) m_param[a] = d;
      else if (a == 8'd16) m_sync_en = d[0];
      else if (a == 8'd17) m_sync_req = d[0];
      else if (a == 8'd18) m_mode = d[1:0];
      else if (a == 8'd19) m_pol = d[2:0];
      else if (a >= 8'd20 && a < 8'd28) m_shadow[a - 8'd20] = d;
      else if (a == 8'd28) m_apply = d[0];
    end
    #2;
    bus_wr = 1'b0;
    check_outputs();
    check_read(ra);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 12; i++) m_param[i] = 8'h00;
    for (int s = 0; s < 8; s++) begin m_shadow[s] = 8'h00; m_active[s] = 8'h00; end
    m_sync_en = 0; m_sync_req = 0; m_apply = 0; m_sticky = 0; m_done = 0;
    m_mode = 2'b00; m_pol = 3'b000;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    pll_locked_n = 1'b1; params_unsupported = 0; sync_pin_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    // R10: defaults while held in reset
    check(cfg_done == 1'b0 && lane_invert == 3'b0 && cal_active == 64'h0, "R10 reset outputs",
          {cfg_done, lane_invert}, 4'h0);
    check(sync_n_out == sync_pin_n, "R10 sync follows pin", sync_n_out, sync_pin_n);
    check(lane_sync_off == 1'b0 && pattern_max == 1'b0, "R10 R8 mode default", pattern_max, 1'b0);
    @(negedge clk);
    pll_locked_n = 1'b0; sync_pin_n = 1'b1;
    rst_n = 1'b1;
    for (int a = 0; a < 32; a++) check_read(8'(a)); // R10 all registers zero after reset

    // R1: checksum wraps past 255
    for (int i = 0; i < 12; i++) step(1, 8'(i), 8'hFF, 0, 0, 1, 8'd12);
    check(bus_rdata == 8'hF4, "R1 wrapped checksum", bus_rdata, 8'hF4);
    step(1, 8'd12, 8'h55, 0, 0, 1, 8'd12); // R1 write to checksum ignored
    step(1, 8'd15, 8'hFF, 0, 1, 1, 8'd15); // R4 write to status ignored

    // R2: pulse and read-back
    step(1, 8'd13, 8'h01, 0, 0, 1, 8'd13);
    step(0, 8'd0, 8'h00, 0, 0, 1, 8'd13);
    step(1, 8'd13, 8'hFE, 0, 0, 1, 8'd13); // bit 0 clear: no pulse

    // R3: sticky set, clear, set-wins
    step(0, 8'd0, 8'h00, 1, 0, 1, 8'd15);
    step(0, 8'd0, 8'h00, 0, 0, 1, 8'd15);
    step(1, 8'd14, 8'h01, 1, 0, 1, 8'd15); // simultaneous: stays set
    step(1, 8'd14, 8'h01, 0, 0, 1, 8'd15); // clears
    step(0, 8'd0, 8'h00, 0, 0, 1, 8'd15);

    // R5: override on/off
    step(1, 8'd17, 8'h01, 0, 0, 1, 8'd17);
    step(1, 8'd16, 8'h01, 0, 0, 1, 8'd16);
    step(1, 8'd17, 8'h00, 0, 0, 0, 8'd17);
    step(1, 8'd16, 8'h00, 0, 0, 0, 8'd16);

    // R7: staged then applied, then write while applied
    step(1, 8'd20, 8'hA5, 0, 0, 1, 8'd20);
    step(1, 8'd27, 8'h3C, 0, 0, 1, 8'd27);
    step(1, 8'd28, 8'h01, 0, 0, 1, 8'd28);
    step(0, 8'd0, 8'h00, 0, 0, 1, 8'd28);
    step(1, 8'd23, 8'h77, 0, 0, 1, 8'd23);
    step(1, 8'd28, 8'h00, 0, 0, 1, 8'd28);
    step(1, 8'd21, 8'h11, 0, 0, 1, 8'd21);

    // R9: unmapped write ignored, reads zero
    step(1, 8'd29, 8'hFF, 0, 0, 1, 8'd29);
    step(1, 8'hFF, 8'hFF, 0, 0, 1, 8'hFF);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a, d, ra;
      bit wr, pll, uns, pin;
      a   = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 32);
      d   = 8'($urandom);
      ra  = 8'($urandom % 40);
      wr  = ($urandom % 4) != 0;
      pll = ($urandom % 8) == 0;
      uns = ($urandom % 2) == 0;
      pin = ($urandom % 2) == 0;
      if (a == 8'd28 && ($urandom % 2) == 0) d[0] = 1'b1;
      step(wr, a, d, pll, uns, pin, ra);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule